// File: doc/BRIEF.md
# Per-Branch Frontend Stall Accounting Table

This block keeps a small ring of rows, one for each branch the core has fetched and not yet retired, and uses them to charge lost frontend cycles to the right place in a cycles-per-instruction breakdown. Each row collects the fetch-stall cycles that follow its branch, split by cause: first-level instruction cache, second-level instruction cache, or instruction TLB. It also collects a penalty count for as long as the branch sits in the reorder buffer.

When a branch retires, its row is reported to an external bank of global counters. The three instruction-side counts are always sent. The penalty count is sent only when the branch was mispredicted. After a mispredicted branch retires, the block also asks the global branch counter to step once per cycle until correct-path instructions reach the reorder buffer.

A mispredict resolution works in three ways at once. It cuts away every younger row. It clears the stall counts that the wrong path left in the branch's own row. It moves allocation so that the next fetched branch takes the row right after it. As a result, stalls on a wrong path never reach the global counters.

Top module: `frontend_loss_table`

## Requirements
- R1: While reset is held and right after it, `side_vld`, `brp_vld`, `brp_inc` and `tbl_full` are low and all add values are zero.
- R2: A branch fetch takes the next free row and clears it. When `ROWS` branches are in flight, `tbl_full` is high and a further fetch is dropped without touching any row. Retiring a branch lowers `tbl_full`.
- R3: In each cycle, `fstall` adds one to a counter of the youngest fetched branch's row. The code 2'b01 selects the first-level instruction cache count, 2'b10 the second-level count and 2'b11 the TLB count. 2'b00 adds nothing.
- R4: A retire with at least one dispatched branch in flight raises `side_vld` for exactly the next cycle. It also presents the oldest row's three stall counts, as they stood before the retire edge, on `l1i_add`, `l2i_add` and `itlb_add`. `brp_vld` rises with it only if that row is marked mispredicted.
- R5: A row's penalty count grows by one for each clock edge at which its branch was dispatched before that edge and not yet retired, and `rob_full` was low. The value on `brp_add` is the count as it stood before the retire edge.
- R6: A mispredict resolution whose ROB ID matches a dispatched row does four things. It marks that row, clears its three stall counts, drops every younger row, and makes that row the youngest fetched and dispatched.
- R7: A resolution whose ROB ID matches no dispatched row, and a resolution reported as correctly predicted, change nothing.
- R8: From the cycle after a mispredicted branch retires, `brp_inc` is high in every cycle in which `rob_enter` is low. It stays low from the first cycle in which `rob_enter` is high until the next mispredicted retire.
- R9: When a mispredict resolution and a branch fetch or dispatch fall in the same cycle, the resolution takes effect and the fetch or dispatch is dropped.
- R10: When a retire and the mispredict resolution of a younger branch fall in the same cycle, both take effect. Only the rows from the oldest survivor up to the resolved branch remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_fetch | input | 1 | A branch was fetched and decoded this cycle |
| br_disp | input | 1 | The oldest undispatched branch enters the reorder buffer |
| disp_rob | input | ROBW | ROB ID of the dispatching branch |
| br_res | input | 1 | A branch resolved this cycle |
| res_rob | input | ROBW | ROB ID of the resolved branch |
| res_mis | input | 1 | The resolved branch was mispredicted |
| br_retire | input | 1 | The oldest branch retires |
| fstall | input | 2 | Fetch-stall cause for this cycle (00 none, 01 L1 I-cache, 10 L2 I-cache, 11 I-TLB) |
| rob_full | input | 1 | Reorder buffer is full this cycle |
| rob_enter | input | 1 | New instructions enter the reorder buffer this cycle |
| tbl_full | output | 1 | Every row is in use; fetch of a further branch must stall |
| side_vld | output | 1 | Stall counts of a retired branch are valid |
| l1i_add | output | CW | First-level instruction cache stall cycles to add |
| l2i_add | output | CW | Second-level instruction cache stall cycles to add |
| itlb_add | output | CW | Instruction TLB stall cycles to add |
| brp_vld | output | 1 | Penalty of a retired mispredicted branch is valid |
| brp_add | output | CW | Branch penalty cycles to add |
| brp_inc | output | 1 | Step the global branch counter by one this cycle |

## Verification
Two pairs of functions can coincide. The first is a mispredict resolution together with a fetch or dispatch. It is provoked by resolving the older of two branches while fetch is asserted. It is judged by later retires: the oldest row must report only the stalls charged after the redirect, and exactly one surviving younger branch must retire before `side_vld` stays low. The second is a retire together with the resolution of a younger branch in the same cycle. It is judged by the penalty reported for the resolved branch and by the absence of any third retire report.

// File: rtl/frontend_loss_table.sv
module frontend_loss_table #(
  parameter int ROWS = 8,
  parameter int ROBW = 6,
  parameter int CW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_fetch,
  input  logic            br_disp,
  input  logic [ROBW-1:0] disp_rob,
  input  logic            br_res,
  input  logic [ROBW-1:0] res_rob,
  input  logic            res_mis,
  input  logic            br_retire,
  input  logic [1:0]      fstall,
  input  logic            rob_full,
  input  logic            rob_enter,
  output logic            tbl_full,
  output logic            side_vld,
  output logic [CW-1:0]   l1i_add,
  output logic [CW-1:0]   l2i_add,
  output logic [CW-1:0]   itlb_add,
  output logic            brp_vld,
  output logic [CW-1:0]   brp_add,
  output logic            brp_inc
);
  localparam int PW   = $clog2(ROWS);
  localparam int CNTW = PW + 1;

  logic [ROBW-1:0] rid [ROWS];
  logic [CW-1:0]   c1 [ROWS];
  logic [CW-1:0]   c2 [ROWS];
  logic [CW-1:0]   ct [ROWS];
  logic [CW-1:0]   bp [ROWS];
  logic [ROWS-1:0] mp;

  logic [PW-1:0]   hd, tl, fp, hoff, hidx;
  logic [CNTW-1:0] nf, nd;
  logic            drn, found;

  logic [ROWS-1:0] zap, kill, acc, wid, live;

  assign tbl_full = (nf == CNTW'(ROWS));
  wire do_ret   = br_retire & (nd != '0);
  wire mis_hit  = br_res & res_mis & found & ~(do_ret & (hoff == '0));
  wire do_fetch = br_fetch & ~tbl_full & ~mis_hit;
  wire do_disp  = br_disp & (nd < nf) & ~mis_hit;
  assign hidx    = hd + hoff;
  assign brp_inc = drn & ~rob_enter;

  always_comb begin
    found = 1'b0;
    hoff  = '0;
    for (int k = 0; k < ROWS; k++)
      if (!found && CNTW'(k) < nd && rid[hd + PW'(k)] == res_rob) begin
        found = 1'b1;
        hoff  = PW'(k);
      end
  end

  always_comb
    for (int i = 0; i < ROWS; i++) begin
      zap[i]  = do_fetch && PW'(i) == fp + PW'(1);
      kill[i] = mis_hit && PW'(i) == hidx;
      acc[i]  = PW'(i) == fp;
      wid[i]  = do_disp && PW'(i) == tl + PW'(1);
      live[i] = {1'b0, PW'(PW'(i) - hd)} < nd;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        rid[i] <= '0;
        c1[i]  <= '0;
        c2[i]  <= '0;
        ct[i]  <= '0;
        bp[i]  <= '0;
      end
      mp <= '0;
    end else begin
      for (int i = 0; i < ROWS; i++) begin
        if (zap[i]) begin
          c1[i] <= '0;
          c2[i] <= '0;
          ct[i] <= '0;
          bp[i] <= '0;
          mp[i] <= 1'b0;
        end else begin
          if (kill[i]) begin
            mp[i] <= 1'b1;
            c1[i] <= '0;
            c2[i] <= '0;
            ct[i] <= '0;
          end else if (acc[i]) begin
            case (fstall)
              2'b01:   c1[i] <= c1[i] + 1'b1;
              2'b10:   c2[i] <= c2[i] + 1'b1;
              2'b11:   ct[i] <= ct[i] + 1'b1;
              default: ;
            endcase
          end
          if (wid[i]) rid[i] <= disp_rob;
          if (live[i] && !rob_full) bp[i] <= bp[i] + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hd <= '0;
      tl <= PW'(ROWS - 1);
      fp <= PW'(ROWS - 1);
      nf <= '0;
      nd <= '0;
    end else begin
      hd <= hd + PW'(do_ret);
      if (mis_hit) begin
        tl <= hidx;
        fp <= hidx;
        nf <= CNTW'(hoff) + CNTW'(1) - CNTW'(do_ret);
        nd <= CNTW'(hoff) + CNTW'(1) - CNTW'(do_ret);
      end else begin
        tl <= tl + PW'(do_disp);
        fp <= fp + PW'(do_fetch);
        nf <= nf + CNTW'(do_fetch) - CNTW'(do_ret);
        nd <= nd + CNTW'(do_disp) - CNTW'(do_ret);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      side_vld <= 1'b0;
      brp_vld  <= 1'b0;
      l1i_add  <= '0;
      l2i_add  <= '0;
      itlb_add <= '0;
      brp_add  <= '0;
      drn      <= 1'b0;
    end else begin
      side_vld <= do_ret;
      brp_vld  <= do_ret & mp[hd];
      l1i_add  <= do_ret ? c1[hd] : '0;
      l2i_add  <= do_ret ? c2[hd] : '0;
      itlb_add <= do_ret ? ct[hd] : '0;
      brp_add  <= (do_ret & mp[hd]) ? bp[hd] : '0;
      if (do_ret && mp[hd]) drn <= 1'b1;
      else if (rob_enter)   drn <= 1'b0;
    end
endmodule

// File: rtl/frontend_loss_table_chk.sv
module frontend_loss_table_chk (
  input logic clk,
  input logic rst_n,
  input logic br_retire,
  input logic br_res,
  input logic tbl_full,
  input logic side_vld,
  input logic brp_vld,
  input logic brp_inc,
  input logic rob_enter
);
  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full && !br_retire && !br_res |=> tbl_full);

  assert_side_follows_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    side_vld |-> $past(br_retire));

  assert_penalty_with_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    brp_vld |-> side_vld);

  assert_inc_stops_on_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rob_enter |-> !brp_inc);

  assert_inc_starts_at_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brp_inc) |-> brp_vld);
endmodule

bind frontend_loss_table frontend_loss_table_chk u_chk (.*);

// File: tb/frontend_loss_table_bench.sv
module frontend_loss_table_bench;
  localparam int ROWS = 8, ROBW = 6, CW = 16;
  localparam int NV = 6;
  // n1, n2, nt, cycles with rob_full, stalls after resolve, mispredict, drain length
  localparam int VEC [NV][7] = '{
    '{3, 2, 1, 0, 0, 0, 1},
    '{0, 0, 0, 0, 0, 1, 1},
    '{4, 1, 2, 3, 2, 1, 3},
    '{1, 5, 0, 2, 1, 0, 1},
    '{2, 2, 2, 6, 3, 1, 2},
    '{0, 0, 4, 1, 0, 0, 1}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, br_fetch, br_disp, br_res, res_mis, br_retire, rob_full, rob_enter;
  logic [ROBW-1:0] disp_rob, res_rob;
  logic [1:0] fstall;
  logic tbl_full, side_vld, brp_vld, brp_inc;
  logic [CW-1:0] l1i_add, l2i_add, itlb_add, brp_add;

  int nchk = 0, nerr = 0;

  frontend_loss_table #(.ROWS(ROWS), .ROBW(ROBW), .CW(CW)) u_frontend_loss_table (
    .clk(clk), .rst_n(rst_n), .br_fetch(br_fetch), .br_disp(br_disp), .disp_rob(disp_rob),
    .br_res(br_res), .res_rob(res_rob), .res_mis(res_mis), .br_retire(br_retire),
    .fstall(fstall), .rob_full(rob_full), .rob_enter(rob_enter), .tbl_full(tbl_full),
    .side_vld(side_vld), .l1i_add(l1i_add), .l2i_add(l2i_add), .itlb_add(itlb_add),
    .brp_vld(brp_vld), .brp_add(brp_add), .brp_inc(brp_inc));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    br_fetch = 0; br_disp = 0; br_res = 0; res_mis = 0; br_retire = 0;
    fstall = 2'b00; rob_full = 0; rob_enter = 0; disp_rob = '0; res_rob = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic fetch_one();
    idle(); br_fetch = 1; cyc(); idle();
  endtask

  task automatic disp_one(int id);
    idle(); br_disp = 1; disp_rob = ROBW'(id); cyc(); idle();
  endtask

  task automatic retire_one();
    idle(); br_retire = 1; cyc(); idle();
  endtask

  task automatic run_vec(int v);
    int n1, n2, nt, nfl, n4, mis, drn, tot;
    n1 = VEC[v][0]; n2 = VEC[v][1]; nt = VEC[v][2]; nfl = VEC[v][3];
    n4 = VEC[v][4]; mis = VEC[v][5]; drn = VEC[v][6]; tot = n1 + n2 + nt;
    fetch_one();
    disp_one(8 + v);
    for (int k = 0; k < tot; k++) begin
      fstall = (k < n1) ? 2'b01 : (k < n1 + n2) ? 2'b10 : 2'b11;
      rob_full = (k < nfl);
      cyc(); idle();
    end
    br_res = 1; res_rob = ROBW'(8 + v); res_mis = mis[0]; cyc(); idle();
    for (int k = 0; k < n4; k++) begin fstall = 2'b01; cyc(); idle(); end
    retire_one();
    chk($sformatf("R4 vec%0d side_vld", v), int'(side_vld), 1);
    chk($sformatf("R3 vec%0d l1i_add", v), int'(l1i_add), (mis != 0 ? 0 : n1) + n4);
    chk($sformatf("R3 vec%0d l2i_add", v), int'(l2i_add), mis != 0 ? 0 : n2);
    chk($sformatf("R6 vec%0d itlb_add", v), int'(itlb_add), mis != 0 ? 0 : nt);
    chk($sformatf("R4 vec%0d brp_vld", v), int'(brp_vld), mis);
    if (mis != 0)
      chk($sformatf("R5 vec%0d brp_add", v), int'(brp_add), tot - nfl + 1 + n4);
    chk($sformatf("R8 vec%0d brp_inc first", v), int'(brp_inc), mis);
    for (int k = 1; k < drn; k++) begin
      cyc();
      chk($sformatf("R8 vec%0d brp_inc hold", v), int'(brp_inc), mis);
      chk($sformatf("R4 vec%0d side_vld pulse", v), int'(side_vld), 0);
    end
    rob_enter = 1; #1;
    chk($sformatf("R8 vec%0d brp_inc on enter", v), int'(brp_inc), 0);
    cyc(); idle(); #1;
    chk($sformatf("R8 vec%0d brp_inc after enter", v), int'(brp_inc), 0);
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    cyc(); cyc(); cyc();
    chk("R1 reset side_vld", int'(side_vld), 0);
    chk("R1 reset brp_vld", int'(brp_vld), 0);
    chk("R1 reset brp_inc", int'(brp_inc), 0);
    chk("R1 reset tbl_full", int'(tbl_full), 0);
    chk("R1 reset l1i_add", int'(l1i_add), 0);
    rst_n = 1;
    cyc();
    chk("R1 after reset side_vld", int'(side_vld), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R2: fill every row, attempt one more fetch, check nothing was overwritten
    fetch_one();
    fstall = 2'b01;
    for (int k = 0; k < 5; k++) cyc();
    idle();
    for (int k = 0; k < ROWS - 1; k++) fetch_one();
    chk("R2 tbl_full when all rows used", int'(tbl_full), 1);
    fetch_one();
    chk("R2 tbl_full after dropped fetch", int'(tbl_full), 1);
    for (int k = 0; k < ROWS; k++) disp_one(10 + k);
    retire_one();
    chk("R2 oldest row kept side_vld", int'(side_vld), 1);
    chk("R2 oldest row kept l1i_add", int'(l1i_add), 5);
    chk("R2 tbl_full drops after retire", int'(tbl_full), 0);
    for (int k = 0; k < ROWS - 1; k++) retire_one();
    chk("R2 last row l1i_add", int'(l1i_add), 0);
    chk("R2 no penalty on good branches", int'(brp_vld), 0);
    cyc();
    chk("R2 all rows freed", int'(side_vld), 0);

    // R7: unmatched and correctly predicted resolutions
    fetch_one();
    disp_one(40);
    fstall = 2'b01; cyc(); cyc();
    br_res = 1; res_rob = ROBW'(41); res_mis = 1; cyc(); idle();
    fstall = 2'b01; br_res = 1; res_rob = ROBW'(40); res_mis = 0; cyc(); idle();
    retire_one();
    chk("R7 stall counts untouched", int'(l1i_add), 4);
    chk("R7 no mispredict mark", int'(brp_vld), 0);
    chk("R7 no drain request", int'(brp_inc), 0);

    // R9: resolution and fetch in the same cycle
    fetch_one(); disp_one(20);
    fetch_one(); disp_one(21);
    br_res = 1; res_rob = ROBW'(20); res_mis = 1; br_fetch = 1; cyc(); idle();
    fstall = 2'b01; cyc(); cyc(); cyc(); idle();
    fetch_one(); disp_one(22);
    retire_one();
    chk("R9 redirected row l1i_add", int'(l1i_add), 3);
    chk("R9 redirected row brp_vld", int'(brp_vld), 1);
    chk("R5 redirected row brp_add", int'(brp_add), 8);
    chk("R8 drain after retire", int'(brp_inc), 1);
    rob_enter = 1; br_retire = 1; cyc(); idle(); #1;
    chk("R9 next branch side_vld", int'(side_vld), 1);
    chk("R9 next branch brp_vld", int'(brp_vld), 0);
    chk("R9 next branch l1i_add", int'(l1i_add), 0);
    chk("R8 drain cleared", int'(brp_inc), 0);
    retire_one();
    chk("R9 dropped fetch left no row", int'(side_vld), 0);

    // R10: retire and younger resolution in the same cycle
    fetch_one(); disp_one(30);
    fetch_one(); disp_one(31);
    fetch_one(); disp_one(32);
    fstall = 2'b01; cyc(); cyc(); idle();
    br_retire = 1; br_res = 1; res_rob = ROBW'(31); res_mis = 1; cyc(); idle();
    chk("R10 oldest side_vld", int'(side_vld), 1);
    chk("R10 oldest l1i_add", int'(l1i_add), 0);
    chk("R10 oldest brp_vld", int'(brp_vld), 0);
    retire_one();
    chk("R10 resolved row brp_vld", int'(brp_vld), 1);
    chk("R10 resolved row brp_add", int'(brp_add), 5);
    chk("R6 resolved row l1i_add", int'(l1i_add), 0);
    chk("R8 drain after resolved retire", int'(brp_inc), 1);
    rob_enter = 1; br_retire = 1; cyc(); idle(); #1;
    chk("R10 youngest row discarded", int'(side_vld), 0);
    chk("R8 drain ends", int'(brp_inc), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule